// File: doc/BRIEF.md
# Converter Readout Slave with Clock Stretching

This block is the two-wire serial slave side of an 8-bit sampling converter. It runs on a system clock that is much faster than the serial clock and filters both bus lines through synchronisers. It watches for START, repeated START and STOP conditions and compares the first byte after a START against its own 7-bit address. The lowest address bit comes from a strap input.

When a read address matches, the block acknowledges it. From the falling edge that ends the acknowledge bit, it pulls the serial clock low. While the clock is held, an internal timer runs a track/acquire phase and then a conversion phase, both counted in ticks of a divided internal clock. At the end of the conversion the value on the sample input is captured, the first result bit is placed on the data line, and the clock is let go. The result bits go out most significant first. A master acknowledge starts a fresh conversion, with the clock held again, before the next byte. A master not-acknowledge ends the read.

Both bus lines are driven only as open-drain pull-down enables. The block always works in the internal conversion clock mode, which is the mode selected after reset. Write transfers are not acknowledged. A high-speed master code byte is passed over, and the block then waits for the next START.

Top module: `adc_i2c_slave`

## Requirements
- R1: During and right after reset, both pull-down enables (`scl_oe`, `sda_oe`) are inactive.
- R2: The slave acknowledges by pulling SDA low during the ninth clock only when the first seven bits after a START equal 110010 followed by the level of `addr_sel`, and the eighth bit is 1 (read).
- R3: After a mismatched address, the slave neither acknowledges, drives SDA nor stretches SCL until the next START. A valid address that follows a repeated START is then served normally.
- R4: A first byte of the form 00001xxx (high-speed master code) is not acknowledged, and a read address sent after the following repeated START is acknowledged.
- R5: A matching address with the direction bit 0 (write) is not acknowledged.
- R6: From the ninth falling SCL edge of an accepted read address, SCL is held low for at least (2 + CONV_TICKS) × ICLK_DIV system cycles (40 by default). It is released no later than 60 cycles after that edge.
- R7: Each returned byte equals the value on `sample_i` at the end of its conversion and is sent most significant bit first. A change of `sample_i` after SCL is released does not alter the byte in flight.
- R8: A master acknowledge after a data byte starts a new conversion with SCL held low for the R6 duration. The next byte carries the freshly captured sample.
- R9: After a master not-acknowledge, SDA stays released and SCL is not stretched for any further clocks until a START. After a STOP, both enables are inactive.
- R10: The slave changes its SDA drive only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Serial clock line level |
| sda_i | input | 1 | Serial data line level |
| addr_sel | input | 1 | Strap that sets the lowest slave address bit |
| sample_i | input | 8 | Converter sample, captured at the end of each conversion |
| scl_oe | output | 1 | Pulls SCL low when 1 (clock stretching) |
| sda_oe | output | 1 | Pulls SDA low when 1 (acknowledge and data) |

## Verification
A wrong address comparison or a wrong direction decode shows up in the ninth clock of the address byte as a missing or unexpected low on SDA. A stuck conversion timer shows up on the first data bit as an SCL stretch that is too short or that never ends.

A bit counter that is off by one shifts every following data bit and moves the point where SDA is released for the master's acknowledge, so a single byte read exposes it. A sequencer that does not return to its idle state after a not-acknowledge shows up on the next dummy byte as a driven SDA or a stretched clock.

// File: rtl/adc_i2c_pkg.sv
package adc_i2c_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_AACK,
        ST_CONV,
        ST_REL,
        ST_TX,
        ST_MACK,
        ST_WAIT
    } slv_state_e;

    localparam logic [5:0] ADDR_HI = 6'b110010;
    localparam int ACQ_TICKS = 2;

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_lvl,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    typedef struct packed {
        logic [STAGES-1:0] scl_sh;
        logic [STAGES-1:0] sda_sh;
        logic              scl_p;
        logic              sda_p;
    } sync_t;

    sync_t sy_d, sy_q;

    assign scl_lvl = sy_q.scl_sh[STAGES-1];
    assign sda_lvl = sy_q.sda_sh[STAGES-1];

    always_comb begin
        sy_d        = sy_q;
        sy_d.scl_sh = {sy_q.scl_sh[STAGES-2:0], scl_i};
        sy_d.sda_sh = {sy_q.sda_sh[STAGES-2:0], sda_i};
        sy_d.scl_p  = scl_lvl;
        sy_d.sda_p  = sda_lvl;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sy_q <= '1;
        end else begin
            sy_q <= sy_d;
        end
    end

    assign scl_rise  = scl_lvl & ~sy_q.scl_p;
    assign scl_fall  = ~scl_lvl & sy_q.scl_p;
    assign start_det = scl_lvl & sy_q.scl_p & sy_q.sda_p & ~sda_lvl;
    assign stop_det  = scl_lvl & sy_q.scl_p & ~sy_q.sda_p & sda_lvl;

endmodule

// File: rtl/adc_conv_timer.sv
module adc_conv_timer #(
    parameter int ICLK_DIV   = 4,
    parameter int ACQ_TICKS  = 2,
    parameter int CONV_TICKS = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic done
);

    localparam int TOTAL = ACQ_TICKS + CONV_TICKS;
    localparam int CW    = $clog2(TOTAL + 1);
    localparam int PW    = (ICLK_DIV > 1) ? $clog2(ICLK_DIV) : 1;

    typedef struct packed {
        logic          busy;
        logic [PW-1:0] pre;
        logic [CW-1:0] cnt;
    } tmr_t;

    tmr_t tm_d, tm_q;
    logic tick;

    generate
        if (ICLK_DIV == 1) begin : g_nodiv
            assign tick = 1'b1;
        end else begin : g_div
            assign tick = (tm_q.pre == PW'(ICLK_DIV - 1));
        end
    endgenerate

    always_comb begin
        tm_d = tm_q;
        done = 1'b0;
        if (start) begin
            tm_d.busy = 1'b1;
            tm_d.pre  = '0;
            tm_d.cnt  = '0;
        end else if (tm_q.busy) begin
            tm_d.pre = tick ? '0 : tm_q.pre + 1'b1;
            if (tick) begin
                if (tm_q.cnt == CW'(TOTAL - 1)) begin
                    tm_d.busy = 1'b0;
                    done      = 1'b1;
                end else begin
                    tm_d.cnt = tm_q.cnt + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tm_q <= '0;
        end else begin
            tm_q <= tm_d;
        end
    end

    assign busy = tm_q.busy;

    // R6: the sequencer never restarts a conversion that is still running
    a_r6_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !tm_q.busy);

endmodule

// File: rtl/adc_i2c_slave.sv
module adc_i2c_slave
    import adc_i2c_pkg::*;
#(
    parameter int ICLK_DIV    = 4,
    parameter int CONV_TICKS  = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    input  logic       addr_sel,
    input  logic [7:0] sample_i,
    output logic       scl_oe,
    output logic       sda_oe
);

    typedef struct packed {
        slv_state_e state;
        logic [3:0] cnt;
        logic [7:0] shreg;
        logic       ack_seen;
        logic       scl_oe;
        logic       sda_oe;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_det, stop_det;
    logic conv_start, conv_busy, conv_done;

    i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_lvl   (scl_lvl),
        .sda_lvl   (sda_lvl),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    adc_conv_timer #(
        .ICLK_DIV   (ICLK_DIV),
        .ACQ_TICKS  (ACQ_TICKS),
        .CONV_TICKS (CONV_TICKS)
    ) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .start (conv_start),
        .busy  (conv_busy),
        .done  (conv_done)
    );

    always_comb begin
        ctl_d      = ctl_q;
        conv_start = 1'b0;
        if (stop_det) begin
            ctl_d.state  = ST_IDLE;
            ctl_d.cnt    = '0;
            ctl_d.sda_oe = 1'b0;
            ctl_d.scl_oe = 1'b0;
        end else if (start_det) begin
            ctl_d.state  = ST_ADDR;
            ctl_d.cnt    = '0;
            ctl_d.sda_oe = 1'b0;
            ctl_d.scl_oe = 1'b0;
        end else begin
            unique case (ctl_q.state)
                ST_IDLE, ST_WAIT: begin
                end
                ST_ADDR: begin
                    if (scl_rise && ctl_q.cnt < 4'd8) begin
                        ctl_d.shreg = {ctl_q.shreg[6:0], sda_lvl};
                        ctl_d.cnt   = ctl_q.cnt + 4'd1;
                    end else if (scl_fall && ctl_q.cnt == 4'd8) begin
                        if (ctl_q.shreg[7:1] == {ADDR_HI, addr_sel} && ctl_q.shreg[0]) begin
                            ctl_d.state  = ST_AACK;
                            ctl_d.sda_oe = 1'b1;
                        end else begin
                            ctl_d.state = ST_WAIT;
                        end
                    end
                end
                ST_AACK: begin
                    if (scl_fall) begin
                        ctl_d.sda_oe = 1'b0;
                        ctl_d.scl_oe = 1'b1;
                        ctl_d.state  = ST_CONV;
                        conv_start   = 1'b1;
                    end
                end
                ST_CONV: begin
                    if (conv_done) begin
                        ctl_d.shreg  = sample_i;
                        ctl_d.sda_oe = ~sample_i[7];
                        ctl_d.cnt    = '0;
                        ctl_d.state  = ST_REL;
                    end
                end
                ST_REL: begin
                    ctl_d.scl_oe = 1'b0;
                    ctl_d.state  = ST_TX;
                end
                ST_TX: begin
                    if (scl_fall) begin
                        if (ctl_q.cnt == 4'd7) begin
                            ctl_d.sda_oe   = 1'b0;
                            ctl_d.ack_seen = 1'b0;
                            ctl_d.cnt      = '0;
                            ctl_d.state    = ST_MACK;
                        end else begin
                            ctl_d.sda_oe = ~ctl_q.shreg[6];
                            ctl_d.shreg  = {ctl_q.shreg[6:0], 1'b0};
                            ctl_d.cnt    = ctl_q.cnt + 4'd1;
                        end
                    end
                end
                ST_MACK: begin
                    if (scl_rise) begin
                        ctl_d.ack_seen = ~sda_lvl;
                    end else if (scl_fall) begin
                        if (ctl_q.ack_seen) begin
                            ctl_d.scl_oe = 1'b1;
                            ctl_d.state  = ST_CONV;
                            conv_start   = 1'b1;
                        end else begin
                            ctl_d.state = ST_WAIT;
                        end
                    end
                end
                default: ctl_d.state = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{state: ST_IDLE, cnt: '0, shreg: '0, ack_seen: 1'b0,
                       scl_oe: 1'b0, sda_oe: 1'b0};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign scl_oe = ctl_q.scl_oe;
    assign sda_oe = ctl_q.sda_oe;

    // R6: while the timer runs, SCL is held low
    a_r6_stretch_during_conv: assert property (@(posedge clk) disable iff (!rst_n)
        conv_busy |-> ctl_q.scl_oe);

    // R8: conversions only start on a falling SCL edge
    a_r8_conv_start_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |-> scl_fall);

    // R10: SDA drive changes only when the synchronised SCL was low
    a_r10_sda_only_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.sda_oe != $past(ctl_q.sda_oe)) |->
            (!$past(scl_lvl) || $past(start_det) || $past(stop_det)));

    // R9: no drive of either line while waiting for a START
    a_r9_quiet_in_wait: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.state == ST_WAIT) |-> (!ctl_q.sda_oe && !ctl_q.scl_oe));

endmodule

// File: tb/sim_adc_i2c_slave.sv
module sim_adc_i2c_slave;

    localparam int Q = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic       addr_sel = 1'b0;
    logic [7:0] sample = 8'h00;
    logic       scl_oe, sda_oe;
    logic       scl_line, sda_line;

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    int fall_cyc = 0;
    int last_stretch = 0;
    int r10_viol = 0;
    logic prev_scl = 1'b1;
    logic prev_sda_oe = 1'b0;

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    assign scl_line = scl_m & ~scl_oe;
    assign sda_line = sda_m & ~sda_oe;

    adc_i2c_slave u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl_line),
        .sda_i    (sda_line),
        .addr_sel (addr_sel),
        .sample_i (sample),
        .scl_oe   (scl_oe),
        .sda_oe   (sda_oe)
    );

    // R10 monitor: SDA drive must not change across two high SCL samples
    always @(negedge clk) begin
        if (rst_n && scl_line && prev_scl && (sda_oe != prev_sda_oe)) r10_viol++;
        prev_scl    <= scl_line;
        prev_sda_oe <= sda_oe;
    end

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic check_range(input string req, input int act, input int lo, input int hi);
        checks++;
        if (act < lo || act > hi) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d..%0d", req, act, lo, hi);
        end
    endtask

    task automatic waitq();
        repeat (Q) @(negedge clk);
    endtask

    task automatic wait_scl_high();
        int n = 0;
        @(negedge clk);
        while (!scl_line && n < 5000) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic bit_xfer(input logic b, output logic r);
        sda_m = b;
        waitq();
        scl_m = 1'b1;
        wait_scl_high();
        last_stretch = cyc - fall_cyc;
        waitq();
        r = sda_line;
        waitq();
        scl_m = 1'b0;
        fall_cyc = cyc;
        waitq();
    endtask

    task automatic bus_start();
        sda_m = 1'b1;
        waitq();
        scl_m = 1'b1;
        wait_scl_high();
        waitq();
        sda_m = 1'b0;
        waitq();
        scl_m = 1'b0;
        fall_cyc = cyc;
        waitq();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0;
        waitq();
        scl_m = 1'b1;
        wait_scl_high();
        waitq();
        sda_m = 1'b1;
        waitq();
    endtask

    // returns the level seen in the ninth bit (0 = acknowledged)
    task automatic send_byte(input logic [7:0] v, output logic ack_bit);
        logic r;
        for (int i = 7; i >= 0; i--) bit_xfer(v[i], r);
        bit_xfer(1'b1, ack_bit);
    endtask

    task automatic recv_byte(input logic mack, input logic [7:0] nv,
                             output logic [7:0] v, output int st);
        logic r;
        for (int i = 7; i >= 0; i--) begin
            bit_xfer(1'b1, r);
            v[i] = r;
            if (i == 7) begin
                st = last_stretch;
                sample = nv;
            end
        end
        bit_xfer(mack ? 1'b0 : 1'b1, r);
    endtask

    task automatic t_reset();
        check("R1 sda_oe in reset", sda_oe, 1'b0);
        check("R1 scl_oe in reset", scl_oe, 1'b0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        check("R1 sda_oe after reset", sda_oe, 1'b0);
        check("R1 scl_oe after reset", scl_oe, 1'b0);
    endtask

    task automatic t_read_two();
        logic a;
        logic [7:0] v;
        int st;
        addr_sel = 1'b0;
        sample = 8'hA5;
        bus_start();
        send_byte(8'hC9, a);
        check("R2 ack of 1100100 read", a, 1'b0);
        recv_byte(1'b1, 8'h3C, v, st);
        check_range("R6 first stretch", st, 40, 60);
        check("R7 first byte", v, 8'hA5);
        recv_byte(1'b0, 8'h77, v, st);
        check_range("R8 second stretch", st, 40, 60);
        check("R8 fresh sample", v, 8'h3C);
        recv_byte(1'b0, 8'h77, v, st);
        check("R9 no drive after nack", v, 8'hFF);
        check_range("R9 no stretch after nack", st, 0, 30);
        bus_stop();
        check("R9 sda_oe after stop", sda_oe, 1'b0);
        check("R9 scl_oe after stop", scl_oe, 1'b0);
    endtask

    task automatic t_addr_sel();
        logic a;
        logic [7:0] v;
        int st;
        addr_sel = 1'b1;
        sample = 8'h81;
        bus_start();
        send_byte(8'hC9, a);
        check("R2 no ack of 1100100 when strap high", a, 1'b1);
        bus_start();
        send_byte(8'hCB, a);
        check("R2 ack of 1100101 when strap high", a, 1'b0);
        recv_byte(1'b0, 8'h00, v, st);
        check("R7 byte with strap high", v, 8'h81);
        bus_stop();
        addr_sel = 1'b0;
    endtask

    task automatic t_mismatch();
        logic a;
        logic [7:0] v;
        int st;
        sample = 8'h5A;
        bus_start();
        send_byte(8'hCF, a);
        check("R3 no ack of mismatched address", a, 1'b1);
        recv_byte(1'b0, 8'h5A, v, st);
        check("R3 no drive after mismatch", v, 8'hFF);
        check_range("R3 no stretch after mismatch", st, 0, 30);
        bus_start();
        send_byte(8'hC9, a);
        check("R3 ack after repeated start", a, 1'b0);
        recv_byte(1'b0, 8'h00, v, st);
        check("R3 byte after recovery", v, 8'h5A);
        bus_stop();
    endtask

    task automatic t_hs_code();
        logic a;
        logic [7:0] v;
        int st;
        sample = 8'hC3;
        bus_start();
        send_byte(8'h0E, a);
        check("R4 master code not acked", a, 1'b1);
        bus_start();
        send_byte(8'hC9, a);
        check("R4 ack after master code", a, 1'b0);
        recv_byte(1'b0, 8'h00, v, st);
        check("R4 byte after master code", v, 8'hC3);
        bus_stop();
    endtask

    task automatic t_write();
        logic a;
        bus_start();
        send_byte(8'hC8, a);
        check("R5 write address not acked", a, 1'b1);
        bus_stop();
        check("R5 sda_oe idle", sda_oe, 1'b0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        repeat (5) @(negedge clk);
        t_reset();
        repeat (20) @(negedge clk);
        t_read_two();
        t_addr_sel();
        t_mismatch();
        t_hs_code();
        t_write();
        check("R10 sda change while scl high", r10_viol, 0);
        finish_run();
    end

endmodule